// File: doc/BRIEF.md
# Vector store flow merge buffer

This block tracks vector store micro-ops while their memory flows are in flight. A split stage asks for an entry for each micro-op. It receives the index of the lowest free entry in the same cycle, together with a success flag. The entry records the micro-op's payload, its reorder tag and the number of memory flows the micro-op was split into.

Each flow the store pipeline hands back names its entry and lowers that entry's outstanding count. When the count reaches zero, the micro-op is complete. Complete entries leave one per accepted handshake, lowest index first. Each departure goes to the backend, and a pulse updates the store queue at the same time.

Exception bits from the returning flows are merged into the entry, which also keeps the earliest faulting element as the restart point. A misalignment flush marks an entry for reissue, and that mark is reported on the feedback port when the entry leaves. A redirect drops every entry at or after the redirect's reorder tag.

Top module: `vst_merge_buf`

## Requirements
- R1: When `alloc_valid` and `alloc_ready` are both high, `resp_valid` is high in the same cycle, and `resp_idx` is the lowest-numbered entry not in use. `resp_valid` is low otherwise. After reset all 16 entries are free.
- R2: `alloc_ready` is low exactly when all 16 entries are in use or `redir_valid` is high.
- R3: An allocation loads the entry's outstanding count from `alloc_flows`. The entry becomes complete after that many accepted flows that name it. An entry allocated with a count of 0 is complete in the following cycle.
- R4: `wb_valid` is high when at least one entry is complete. `wb_idx`, `wb_info` and `wb_rob` then describe the lowest-numbered complete entry. That entry stays offered until `wb_ready` is high, and it is freed on the edge where `wb_valid` and `wb_ready` are both high.
- R5: `wb_exc` is the bitwise OR of the `flow_exc` values of the entry's accepted flows. When `wb_exc` is nonzero, `wb_vstart` is the smallest `flow_elem` among the flows that carried nonzero `flow_exc`. When `wb_exc` is zero, `wb_vstart` is 0.
- R6: `mis_flush` has no separate qualifier. It marks entry `mis_idx` for reissue if that entry is in use. When a marked entry is accepted for writeback, `fb_valid` pulses with `fb_rob` equal to its reorder tag. A flush naming the entry accepted in that same cycle also sets `fb_valid`.
- R7: An accepted flow that names an entry which is free, or already complete, changes no state.
- R8: `sq_valid` is high exactly in cycles where `wb_valid` and `wb_ready` are both high, and `sq_rob` then equals `wb_rob`.
- R9: While `redir_valid` is high, every in-use entry whose tag is numerically greater than or equal to `redir_rob` is freed at the edge. Such an entry is not offered on `wb_valid` in that cycle.
- R10: `flow_ready` is low only in a cycle where `flow_idx` equals the index being allocated in that same cycle. The flow is then held until the count has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Entry request from the split stage |
| alloc_ready | output | 1 | An entry can be granted |
| alloc_flows | input | 5 | Number of memory flows of the micro-op |
| alloc_rob | input | 8 | Reorder tag of the micro-op |
| alloc_info | input | 16 | Micro-op payload |
| resp_valid | output | 1 | Allocation succeeded this cycle |
| resp_idx | output | 4 | Granted entry |
| flow_valid | input | 1 | Flow returned from the store pipeline |
| flow_ready | output | 1 | Flow accepted |
| flow_idx | input | 4 | Entry the flow belongs to |
| flow_exc | input | 8 | Exception bits of the flow |
| flow_elem | input | 8 | Element index of the flow |
| wb_valid | output | 1 | Complete micro-op offered |
| wb_ready | input | 1 | Backend accepts the writeback |
| wb_idx | output | 4 | Entry being written back |
| wb_info | output | 16 | Payload of that entry |
| wb_rob | output | 8 | Reorder tag of that entry |
| wb_exc | output | 8 | Merged exception bits |
| wb_vstart | output | 8 | Earliest faulting element |
| sq_valid | output | 1 | Store queue update pulse |
| sq_rob | output | 8 | Tag of the updated store |
| redir_valid | input | 1 | Redirect |
| redir_rob | input | 8 | Oldest tag to drop |
| mis_flush | input | 1 | Misalignment flush |
| mis_idx | input | 4 | Entry named by the flush |
| fb_valid | output | 1 | Reissue needed |
| fb_rob | output | 8 | Tag to reissue |

## Verification
The hardest cases to reach from the ports are a full buffer and a flow that lands on the index being granted in the same cycle. Both need a known occupancy. Directed phases hold `wb_ready` low while multi-flow micro-ops are requested until the buffer is full. A redirect with tag 0 then empties it, so the next grant goes to entry 0, and a flow aimed at entry 0 in that cycle must be refused. Random traffic follows, with rare redirects and frequent flushes, compared every cycle against a model kept in the bench.

// File: rtl/vst_merge_buf.sv
module vst_merge_buf #(
  parameter int N  = 16,
  parameter int CW = 5,
  parameter int RW = 8,
  parameter int EW = 8,
  parameter int XW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic [CW-1:0] alloc_flows,
  input  logic [RW-1:0] alloc_rob,
  input  logic [DW-1:0] alloc_info,
  output logic          resp_valid,
  output logic [$clog2(N)-1:0] resp_idx,
  input  logic          flow_valid,
  output logic          flow_ready,
  input  logic [$clog2(N)-1:0] flow_idx,
  input  logic [XW-1:0] flow_exc,
  input  logic [EW-1:0] flow_elem,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [$clog2(N)-1:0] wb_idx,
  output logic [DW-1:0] wb_info,
  output logic [RW-1:0] wb_rob,
  output logic [XW-1:0] wb_exc,
  output logic [EW-1:0] wb_vstart,
  output logic          sq_valid,
  output logic [RW-1:0] sq_rob,
  input  logic          redir_valid,
  input  logic [RW-1:0] redir_rob,
  input  logic          mis_flush,
  input  logic [$clog2(N)-1:0] mis_idx,
  output logic          fb_valid,
  output logic [RW-1:0] fb_rob
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  used_q, done_q, rep_q;
  logic [CW-1:0] cnt_q  [N];
  logic [RW-1:0] rob_q  [N];
  logic [DW-1:0] info_q [N];
  logic [XW-1:0] exc_q  [N];
  logic [EW-1:0] vst_q  [N];

  logic [N-1:0]  kill, cand;
  logic [IW-1:0] free_idx, sel;
  logic          wb_fire, flow_fire;

  always_comb begin
    free_idx = '0;
    sel      = '0;
    for (int i = N-1; i >= 0; i--) begin
      kill[i] = redir_valid && used_q[i] && (rob_q[i] >= redir_rob);
      cand[i] = used_q[i] && done_q[i] && !kill[i];
      if (!used_q[i]) free_idx = IW'(i);
      if (cand[i])    sel      = IW'(i);
    end
  end

  assign alloc_ready = !(&used_q) && !redir_valid;
  assign resp_valid  = alloc_valid && alloc_ready;
  assign resp_idx    = free_idx;
  assign flow_ready  = !(resp_valid && flow_idx == free_idx);
  assign flow_fire   = flow_valid && flow_ready;

  assign wb_valid  = |cand;
  assign wb_idx    = sel;
  assign wb_info   = info_q[sel];
  assign wb_rob    = rob_q[sel];
  assign wb_exc    = exc_q[sel];
  assign wb_vstart = (|exc_q[sel]) ? vst_q[sel] : '0;
  assign wb_fire   = wb_valid && wb_ready;
  assign sq_valid  = wb_fire;
  assign sq_rob    = rob_q[sel];
  assign fb_valid  = wb_fire && (rep_q[sel] || (mis_flush && mis_idx == sel));
  assign fb_rob    = rob_q[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      done_q <= '0;
      rep_q  <= '0;
      for (int i = 0; i < N; i++) begin
        cnt_q[i]  <= '0;
        rob_q[i]  <= '0;
        info_q[i] <= '0;
        exc_q[i]  <= '0;
        vst_q[i]  <= '0;
      end
    end else begin
      if (flow_fire && used_q[flow_idx] && !done_q[flow_idx]) begin
        cnt_q[flow_idx] <= cnt_q[flow_idx] - 1'b1;
        if (cnt_q[flow_idx] == CW'(1)) done_q[flow_idx] <= 1'b1;
        if (|flow_exc) begin
          exc_q[flow_idx] <= exc_q[flow_idx] | flow_exc;
          if (flow_elem < vst_q[flow_idx]) vst_q[flow_idx] <= flow_elem;
        end
      end
      if (mis_flush && used_q[mis_idx]) rep_q[mis_idx] <= 1'b1;
      for (int i = 0; i < N; i++)
        if (kill[i]) begin
          used_q[i] <= 1'b0;
          done_q[i] <= 1'b0;
        end
      if (wb_fire) begin
        used_q[sel] <= 1'b0;
        done_q[sel] <= 1'b0;
      end
      if (resp_valid) begin
        used_q[free_idx] <= 1'b1;
        done_q[free_idx] <= (alloc_flows == '0);
        rep_q[free_idx]  <= 1'b0;
        cnt_q[free_idx]  <= alloc_flows;
        rob_q[free_idx]  <= alloc_rob;
        info_q[free_idx] <= alloc_info;
        exc_q[free_idx]  <= '0;
        vst_q[free_idx]  <= '1;
      end
    end
  end

  p_resp_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !used_q[resp_idx]);
  p_grant_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> used_q[$past(resp_idx)]);
  p_full_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&used_q) |-> !alloc_ready);
  p_wb_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (used_q[wb_idx] && done_q[wb_idx]));
  p_wb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready && !redir_valid) |=> (wb_valid || redir_valid));
  p_sq_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> (wb_valid && wb_ready && sq_rob == wb_rob));
  p_fb_with_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> sq_valid);
  p_redir_nowb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && wb_valid) |-> (wb_rob < redir_rob));
  p_flow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_valid && !flow_ready) |-> (resp_valid && resp_idx == flow_idx));
endmodule

// File: tb/tb_vst_merge_buf.sv
module tb_vst_merge_buf;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, alloc_valid, flow_valid, wb_ready, redir_valid, mis_flush;
  logic [4:0] alloc_flows;
  logic [7:0] alloc_rob, flow_exc, flow_elem, redir_rob;
  logic [15:0] alloc_info;
  logic [3:0] flow_idx, mis_idx;
  logic alloc_ready, resp_valid, flow_ready, wb_valid, sq_valid, fb_valid;
  logic [3:0] resp_idx, wb_idx;
  logic [15:0] wb_info;
  logic [7:0] wb_rob, wb_exc, wb_vstart, sq_rob, fb_rob;

  vst_merge_buf dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_flows(alloc_flows),
    .alloc_rob(alloc_rob), .alloc_info(alloc_info),
    .resp_valid(resp_valid), .resp_idx(resp_idx),
    .flow_valid(flow_valid), .flow_ready(flow_ready), .flow_idx(flow_idx),
    .flow_exc(flow_exc), .flow_elem(flow_elem),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx), .wb_info(wb_info),
    .wb_rob(wb_rob), .wb_exc(wb_exc), .wb_vstart(wb_vstart),
    .sq_valid(sq_valid), .sq_rob(sq_rob),
    .redir_valid(redir_valid), .redir_rob(redir_rob),
    .mis_flush(mis_flush), .mis_idx(mis_idx),
    .fb_valid(fb_valid), .fb_rob(fb_rob)
  );

  int checks = 0, errors = 0;
  bit m_used[16], m_done[16], m_rep[16];
  int m_cnt[16], m_rob[16], m_info[16], m_exc[16], m_vst[16];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int first_free();
    for (int i = 0; i < 16; i++) if (!m_used[i]) return i;
    return -1;
  endfunction

  task automatic step();
    int fi, sel, ev;
    bit e_ready, e_resp, e_fr, wf;
    bit kl[16];
    #1;
    fi = first_free();
    e_ready = (fi >= 0) && !redir_valid;
    e_resp = alloc_valid && e_ready;
    chk("R2 alloc_ready", int'(alloc_ready), int'(e_ready));
    chk("R1 resp_valid", int'(resp_valid), int'(e_resp));
    if (e_resp) chk("R1 resp_idx", int'(resp_idx), fi);
    e_fr = !(e_resp && int'(flow_idx) == fi);
    chk("R10 flow_ready", int'(flow_ready), int'(e_fr));
    sel = -1;
    for (int i = 0; i < 16; i++) begin
      kl[i] = redir_valid && m_used[i] && (m_rob[i] >= int'(redir_rob));
      if (sel < 0 && m_used[i] && m_done[i] && !kl[i]) sel = i;
    end
    chk(redir_valid ? "R9 wb_valid under redirect" : "R3 R4 wb_valid", int'(wb_valid), int'(sel >= 0));
    if (sel >= 0) begin
      chk("R4 wb_idx", int'(wb_idx), sel);
      chk("R4 wb_info", int'(wb_info), m_info[sel]);
      chk("R4 wb_rob", int'(wb_rob), m_rob[sel]);
      chk("R5 wb_exc", int'(wb_exc), m_exc[sel]);
      ev = (m_exc[sel] != 0) ? m_vst[sel] : 0;
      chk("R5 wb_vstart", int'(wb_vstart), ev);
    end
    wf = (sel >= 0) && wb_ready;
    chk("R8 sq_valid", int'(sq_valid), int'(wf));
    if (wf) chk("R8 sq_rob", int'(sq_rob), m_rob[sel]);
    chk("R6 fb_valid", int'(fb_valid), int'(wf && (m_rep[sel] || (mis_flush && int'(mis_idx) == sel))));
    if (wf && fb_valid) chk("R6 fb_rob", int'(fb_rob), m_rob[sel]);
    @(posedge clk);
    // R7: flows naming a free or complete entry leave the model untouched
    if (flow_valid && e_fr && m_used[flow_idx] && !m_done[flow_idx]) begin
      m_cnt[flow_idx]--;
      if (m_cnt[flow_idx] == 0) m_done[flow_idx] = 1;
      if (flow_exc != 0) begin
        m_exc[flow_idx] |= int'(flow_exc);
        if (int'(flow_elem) < m_vst[flow_idx]) m_vst[flow_idx] = int'(flow_elem);
      end
    end
    if (mis_flush && m_used[mis_idx]) m_rep[mis_idx] = 1;
    for (int i = 0; i < 16; i++) if (kl[i]) begin m_used[i] = 0; m_done[i] = 0; end
    if (wf) begin m_used[sel] = 0; m_done[sel] = 0; end
    if (e_resp) begin
      m_used[fi] = 1; m_done[fi] = (alloc_flows == 0); m_rep[fi] = 0;
      m_cnt[fi] = int'(alloc_flows); m_rob[fi] = int'(alloc_rob);
      m_info[fi] = int'(alloc_info); m_exc[fi] = 0; m_vst[fi] = 255;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = 0; flow_valid = 0; wb_ready = 0; redir_valid = 0; mis_flush = 0;
    alloc_flows = 0; alloc_rob = 0; alloc_info = 0; flow_idx = 0; flow_exc = 0;
    flow_elem = 0; redir_rob = 0; mis_idx = 0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tgt;
    void'($urandom(32'd7));
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset alloc_ready", int'(alloc_ready), 1);
    chk("R4 reset wb_valid", int'(wb_valid), 0);
    @(negedge clk);

    // R2: fill all entries while nothing completes
    for (int k = 0; k < 18; k++) begin
      alloc_valid = 1; alloc_flows = 2; alloc_rob = 8'(10 + k); alloc_info = 16'(k * 3);
      step();
    end
    // R9: redirect at tag 0 drops everything
    idle(); redir_valid = 1; redir_rob = 0; alloc_valid = 1; step();
    // R10: flow at the index being granted is held
    idle(); alloc_valid = 1; alloc_flows = 1; alloc_rob = 40; alloc_info = 16'h1234;
    flow_valid = 1; flow_idx = 0; flow_exc = 8'h04; flow_elem = 6; step();
    idle(); flow_valid = 1; flow_idx = 0; flow_exc = 8'h04; flow_elem = 6; step();
    // R3: zero-flow micro-op completes at once
    idle(); alloc_valid = 1; alloc_flows = 0; alloc_rob = 41; alloc_info = 16'h0BAD; step();
    idle(); step();
    // R5: smallest faulting element kept across three flows
    idle(); tgt = first_free(); alloc_valid = 1; alloc_flows = 3; alloc_rob = 50; step();
    idle(); flow_valid = 1; flow_idx = 4'(tgt); flow_exc = 8'h01; flow_elem = 9; step();
    idle(); flow_valid = 1; flow_idx = 4'(tgt); flow_exc = 8'h10; flow_elem = 3; step();
    idle(); flow_valid = 1; flow_idx = 4'(tgt); flow_exc = 8'h02; flow_elem = 7;
    mis_flush = 1; mis_idx = 4'(tgt); step();
    // R4 R6 R8: drain with flagged entry
    idle(); wb_ready = 1; repeat (4) step();

    for (int k = 0; k < 4000; k++) begin
      alloc_valid = ($urandom % 10) < 6;
      alloc_flows = 5'($urandom % 5);
      alloc_rob = 8'($urandom); alloc_info = 16'($urandom);
      flow_valid = ($urandom % 10) < 8;
      flow_idx = 4'($urandom % ((k % 3 == 0) ? 4 : 16));
      flow_exc = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      flow_elem = 8'($urandom);
      wb_ready = ($urandom % 2) == 0;
      redir_valid = ($urandom % 40) == 0;
      redir_rob = 8'($urandom | 32'h80);
      mis_flush = ($urandom % 6) == 0;
      mis_idx = 4'($urandom);
      step();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule